// File: doc/BRIEF.md
# Banked Internal Data Memory Unit

This block is the scratch data memory of a small 8-bit processor core. It holds 256 bytes of synchronous RAM and serves the core through a single valid/ready request port. Each request carries a three-bit operation code, a direct/indirect mode flag, an address or register index, and write data. Read results come back on a response port one cycle after the RAM is read. One request is accepted at a time.

The unit decides where each access lands. Working registers are resolved into one of four eight-byte banks, selected by two bank bits taken from the processor status word. Bit addresses are folded onto a sixteen-byte window. A pre-incrementing stack pointer is kept inside the unit. In the upper half of the address space the addressing mode chooses the target: an indirect access reaches RAM, while a direct access is sent out on a separate special-function-register (SFR) bus. The one exception is the stack pointer, which answers at direct address 0x81 itself.

Top module: `idmem_unit`

## Requirements
- R1: After reset the stack pointer reads 0x07, `req_ready` is high, and `rsp_valid`, `sfr_rd` and `sfr_wr` are low.
- R2: Operation codes are 0 byte read, 1 byte write, 2 register read, 3 register write, 4 bit read, 5 bit write, 6 push and 7 pop. A direct byte access below 0x80 reads or writes RAM. Its read data appears with `rsp_valid` in the cycle after acceptance.
- R3: An indirect byte access (`req_indirect`=1) takes its pointer from R0 of the active bank when `req_addr[0]`=0, and from R1 when it is 1. It reaches all 256 RAM bytes. It holds `req_ready` low for one cycle, and its read data appears two cycles after acceptance.
- R4: A direct byte access to 0x80–0xFF, other than 0x81, raises `sfr_rd` or `sfr_wr` in the acceptance cycle with the address on `sfr_addr`, and leaves RAM unchanged. For a read, `sfr_rdata` is sampled in that cycle and returned on the next.
- R5: A direct byte read or write of 0x81 reads or loads the stack pointer. It never appears on the SFR bus.
- R6: A register access to Rn (`req_addr[2:0]`=n) uses RAM byte bank×8+n. The bank is `bank_sel`, where `bank_sel[1]` is status-word bit 4 and `bank_sel[0]` is bit 3.
- R7: A bit read of bit address a < 0x80 returns, in `rsp_rdata[0]`, bit a[2:0] of RAM byte 0x20+a[6:3]. The upper bits of `rsp_rdata` are zero.
- R8: A bit write takes two cycles, with `req_ready` low in the second. It sets the addressed bit to `req_wdata[0]` and changes no other bit of the byte.
- R9: A bit address of 0x80 or above targets SFR byte {a[7:3],000}. A bit read returns `sfr_rdata` bit a[2:0]. A bit write reads that SFR byte in its first cycle and writes the merged byte in its second.
- R10: A push first increments the stack pointer and then writes at the new value, so the first push after reset lands at 0x08 (R0 of bank 1).
- R11: A pop returns the byte at the stack pointer and then decrements it. Both push and pop wrap modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 2 | Active register bank from status-word bits 4:3 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_op | input | 3 | Operation code |
| req_indirect | input | 1 | 1 = indirect through R0/R1 |
| req_addr | input | 8 | Byte address, bit address or register index |
| req_wdata | input | 8 | Write data (bit 0 for bit writes) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 8 | Read data |
| sfr_rd | output | 1 | SFR bus read strobe |
| sfr_wr | output | 1 | SFR bus write strobe |
| sfr_addr | output | 8 | SFR bus address |
| sfr_wdata | output | 8 | SFR bus write data |
| sfr_rdata | input | 8 | SFR bus read data, valid in the strobe cycle |

## Verification
The bound checker watches every cycle for the following: the two SFR strobes are never high together, SFR traffic only ever carries upper-half addresses and never 0x81, and each push or pop moves the stack pointer by exactly one. It also checks that indirect and bit-write requests hold the port busy, and that every response traces back to a read. Other properties need the bench's reference memory to show them. These are bank aliasing, the bit-window folding, the merge that leaves neighbour bits alone, wrap-around of the stack, and the fact that a direct upper-half access leaves RAM untouched.

// File: rtl/idmem_pkg.sv
package idmem_pkg;
  typedef enum logic [2:0] {
    OP_BYTE_RD = 3'd0,
    OP_BYTE_WR = 3'd1,
    OP_REG_RD  = 3'd2,
    OP_REG_WR  = 3'd3,
    OP_BIT_RD  = 3'd4,
    OP_BIT_WR  = 3'd5,
    OP_PUSH    = 3'd6,
    OP_POP     = 3'd7
  } mem_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PTR  = 2'd1,
    ST_RMW  = 2'd2
  } unit_state_e;
endpackage

// File: rtl/idmem_ram.sv
module idmem_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata_q <= mem[addr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/idmem_addr_map.sv
module idmem_addr_map #(
  parameter int          AW            = 8,
  parameter int          DW            = 8,
  parameter int          REGS_PER_BANK = 8,
  parameter logic [7:0]  BIT_BASE      = 8'h20
) (
  input  logic [1:0]              bank_sel,
  input  logic [$clog2(REGS_PER_BANK)-1:0] reg_idx,
  input  logic [AW-1:0]           bit_addr,
  output logic [AW-1:0]           reg_addr,
  output logic [AW-1:0]           bit_byte,
  output logic [$clog2(DW)-1:0]   bit_pos,
  output logic                    bit_in_sfr
);
  localparam int BP_W = $clog2(DW);

  assign reg_addr   = AW'(bank_sel) * AW'(REGS_PER_BANK) + AW'(reg_idx);
  assign bit_in_sfr = bit_addr[AW-1];
  assign bit_pos    = bit_addr[BP_W-1:0];

  always_comb begin
    if (bit_in_sfr) bit_byte = {bit_addr[AW-1:BP_W], {BP_W{1'b0}}};
    else            bit_byte = AW'(BIT_BASE) + AW'(bit_addr[AW-2:BP_W]);
  end
endmodule

// File: rtl/idmem_stack.sv
module idmem_stack #(
  parameter int            AW       = 8,
  parameter logic [AW-1:0] SP_RESET = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] sp_q,
  output logic [AW-1:0] sp_up
);
  logic [AW-1:0] sp_d;
  logic          sp_en;

  assign sp_up = sp_q + AW'(1);

  always_comb begin
    sp_en = push | pop | load;
    if (load)      sp_d = load_val;
    else if (push) sp_d = sp_up;
    else           sp_d = sp_q - AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= SP_RESET;
    else if (sp_en) sp_q <= sp_d;
  end
endmodule

// File: rtl/idmem_unit.sv
module idmem_unit
  import idmem_pkg::*;
#(
  parameter int            AW       = 8,
  parameter int            DW       = 8,
  parameter int            REGS     = 8,
  parameter logic [AW-1:0] SP_RESET = 8'h07,
  parameter logic [AW-1:0] SP_ADDR  = 8'h81,
  parameter logic [AW-1:0] BIT_BASE = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bank_sel,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic          req_indirect,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          sfr_rd,
  output logic          sfr_wr,
  output logic [AW-1:0] sfr_addr,
  output logic [DW-1:0] sfr_wdata,
  input  logic [DW-1:0] sfr_rdata
);
  localparam int BP_W  = $clog2(DW);
  localparam int IDX_W = $clog2(REGS);

  unit_state_e   state_q, state_d;
  mem_op_e       op;
  logic          accept, hi, is_sp, byte_op;

  logic          ram_we, ram_re;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_rdata;

  logic          sp_push, sp_pop, sp_load;
  logic [AW-1:0] sp_q, sp_up;

  logic [IDX_W-1:0] reg_idx;
  logic [AW-1:0]    reg_addr, bit_byte;
  logic [BP_W-1:0]  bit_pos;
  logic             bit_in_sfr;

  logic          rsp_valid_q, rsp_valid_d;
  logic          meta_en, rsp_hold_q, rsp_hold_d, rsp_bit_q, rsp_bit_d;
  logic [BP_W-1:0] rsp_pos_q;
  logic          hold_en;
  logic [DW-1:0] hold_q, hold_d;
  logic          pend_en, pend_wr_q, pend_wr_d, pend_sfr_q, pend_sfr_d;
  logic [AW-1:0] pend_addr_q, pend_addr_d;
  logic [DW-1:0] pend_data_q, pend_data_d;
  logic [DW-1:0] src_byte, merged;

  assign op      = mem_op_e'(req_op);
  assign accept  = req_valid && (state_q == ST_IDLE);
  assign hi      = req_addr[AW-1];
  assign is_sp   = (req_addr == SP_ADDR);
  assign byte_op = (op == OP_BYTE_RD) || (op == OP_BYTE_WR);
  assign reg_idx = (byte_op && req_indirect) ? IDX_W'(req_addr[0]) : req_addr[IDX_W-1:0];

  idmem_addr_map #(.AW(AW), .DW(DW), .REGS_PER_BANK(REGS), .BIT_BASE(BIT_BASE)) u_map (
    .bank_sel  (bank_sel),
    .reg_idx   (reg_idx),
    .bit_addr  (req_addr),
    .reg_addr  (reg_addr),
    .bit_byte  (bit_byte),
    .bit_pos   (bit_pos),
    .bit_in_sfr(bit_in_sfr)
  );

  idmem_stack #(.AW(AW), .SP_RESET(SP_RESET)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (sp_push),
    .pop     (sp_pop),
    .load    (sp_load),
    .load_val(req_wdata),
    .sp_q    (sp_q),
    .sp_up   (sp_up)
  );

  idmem_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .re   (ram_re),
    .addr (ram_addr),
    .wdata(ram_wdata),
    .rdata(ram_rdata)
  );

  // byte seen in the cycle after a read, and its bit-merged variant
  always_comb begin
    src_byte = rsp_hold_q ? hold_q : ram_rdata;
    merged   = src_byte;
    merged[rsp_pos_q] = pend_data_q[0];
  end

  always_comb begin
    state_d     = state_q;
    ram_we      = 1'b0;
    ram_re      = 1'b0;
    ram_addr    = req_addr;
    ram_wdata   = req_wdata;
    sfr_rd      = 1'b0;
    sfr_wr      = 1'b0;
    sfr_addr    = req_addr;
    sfr_wdata   = req_wdata;
    sp_push     = 1'b0;
    sp_pop      = 1'b0;
    sp_load     = 1'b0;
    rsp_valid_d = 1'b0;
    meta_en     = 1'b0;
    rsp_hold_d  = 1'b0;
    rsp_bit_d   = 1'b0;
    hold_en     = 1'b0;
    hold_d      = sfr_rdata;
    pend_en     = 1'b0;
    pend_wr_d   = 1'b0;
    pend_sfr_d  = bit_in_sfr;
    pend_addr_d = bit_byte;
    pend_data_d = req_wdata;
    case (state_q)
      ST_IDLE: if (accept) begin
        meta_en = 1'b1;
        case (op)
          OP_BYTE_RD, OP_BYTE_WR: begin
            if (req_indirect) begin
              ram_re    = 1'b1;
              ram_addr  = reg_addr;
              pend_en   = 1'b1;
              pend_wr_d = (op == OP_BYTE_WR);
              state_d   = ST_PTR;
            end else if (hi) begin
              if (op == OP_BYTE_RD) begin
                hold_en     = 1'b1;
                rsp_hold_d  = 1'b1;
                rsp_valid_d = 1'b1;
                if (is_sp) hold_d = sp_q;
                else       sfr_rd = 1'b1;
              end else begin
                if (is_sp) sp_load = 1'b1;
                else       sfr_wr  = 1'b1;
              end
            end else begin
              ram_re      = (op == OP_BYTE_RD);
              ram_we      = (op == OP_BYTE_WR);
              rsp_valid_d = (op == OP_BYTE_RD);
            end
          end
          OP_REG_RD: begin
            ram_re      = 1'b1;
            ram_addr    = reg_addr;
            rsp_valid_d = 1'b1;
          end
          OP_REG_WR: begin
            ram_we   = 1'b1;
            ram_addr = reg_addr;
          end
          OP_BIT_RD, OP_BIT_WR: begin
            rsp_bit_d = 1'b1;
            if (bit_in_sfr) begin
              sfr_rd     = 1'b1;
              sfr_addr   = bit_byte;
              hold_en    = 1'b1;
              rsp_hold_d = 1'b1;
            end else begin
              ram_re   = 1'b1;
              ram_addr = bit_byte;
            end
            if (op == OP_BIT_RD) rsp_valid_d = 1'b1;
            else begin
              pend_en = 1'b1;
              state_d = ST_RMW;
            end
          end
          OP_PUSH: begin
            sp_push  = 1'b1;
            ram_we   = 1'b1;
            ram_addr = sp_up;
          end
          default: begin
            sp_pop      = 1'b1;
            ram_re      = 1'b1;
            ram_addr    = sp_q;
            rsp_valid_d = 1'b1;
          end
        endcase
      end
      ST_PTR: begin
        ram_addr  = ram_rdata;
        ram_wdata = pend_data_q;
        ram_we    = pend_wr_q;
        ram_re    = !pend_wr_q;
        rsp_valid_d = !pend_wr_q;
        state_d   = ST_IDLE;
      end
      default: begin
        if (pend_sfr_q) begin
          sfr_wr    = 1'b1;
          sfr_addr  = pend_addr_q;
          sfr_wdata = merged;
        end else begin
          ram_we    = 1'b1;
          ram_addr  = pend_addr_q;
          ram_wdata = merged;
        end
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hold_q <= 1'b0;
      rsp_bit_q  <= 1'b0;
      rsp_pos_q  <= '0;
    end else if (meta_en) begin
      rsp_hold_q <= rsp_hold_d;
      rsp_bit_q  <= rsp_bit_d;
      rsp_pos_q  <= bit_pos;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_wr_q   <= 1'b0;
      pend_sfr_q  <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else if (pend_en) begin
      pend_wr_q   <= pend_wr_d;
      pend_sfr_q  <= pend_sfr_d;
      pend_addr_q <= pend_addr_d;
      pend_data_q <= pend_data_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_bit_q ? {{(DW-1){1'b0}}, src_byte[rsp_pos_q]} : src_byte;
endmodule

// File: rtl/idmem_unit_chk.sv
module idmem_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] req_op,
  input logic       req_indirect,
  input logic       rsp_valid,
  input logic       sfr_rd,
  input logic       sfr_wr,
  input logic [7:0] sfr_addr,
  input logic [7:0] sp_q,
  input logic [1:0] state
);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_sfr_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sfr_rd, sfr_wr}));

  assert_sfr_upper_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd || sfr_wr) |-> sfr_addr[7]);

  assert_sp_not_on_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd || sfr_wr) |-> (sfr_addr != 8'h81));

  assert_push_increments_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 3'd6) |=> (sp_q == $past(sp_q) + 8'd1));

  assert_pop_decrements_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 3'd7) |=> (sp_q == $past(sp_q) - 8'd1));

  assert_bit_write_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 3'd5) |=> (!req_ready ##1 req_ready));

  assert_indirect_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_indirect && (req_op == 3'd0 || req_op == 3'd1)) |=> !req_ready);

  assert_rsp_from_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(acc && (req_op == 3'd0 || req_op == 3'd2 || req_op == 3'd4 || req_op == 3'd7))
                   || $past(state == 2'd1)));
endmodule

bind idmem_unit idmem_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_op      (req_op),
  .req_indirect(req_indirect),
  .rsp_valid   (rsp_valid),
  .sfr_rd      (sfr_rd),
  .sfr_wr      (sfr_wr),
  .sfr_addr    (sfr_addr),
  .sp_q        (sp_q),
  .state       (state_q)
);

// File: tb/idmem_unit_bench.sv
module idmem_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bank_sel;
  logic       req_valid, req_ready, req_indirect;
  logic [2:0] req_op;
  logic [7:0] req_addr, req_wdata;
  logic       rsp_valid;
  logic [7:0] rsp_rdata;
  logic       sfr_rd, sfr_wr;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;

  logic [7:0] ref_mem [256];
  logic [7:0] sfr_mem [256];
  logic [7:0] ref_sp;
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  idmem_unit u_idmem_unit (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_indirect(req_indirect), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sfr_rd(sfr_rd), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  // SFR bus environment: combinational read, write on the clock edge
  assign sfr_rdata = sfr_mem[sfr_addr];
  always @(posedge clk) if (sfr_wr) sfr_mem[sfr_addr] <= sfr_wdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One request through the reference model; called at a falling edge.
  task automatic run(input logic [2:0] op, input logic ind, input logic [7:0] a,
                     input logic [7:0] wd, input string tag);
    logic [7:0] ptr, exp_d, sa, swd, byt;
    bit exp_rsp = 0, two = 0, ex_rd = 0, ex_wr = 0, rmw_sfr = 0;
    int bk = int'(bank_sel);
    exp_d = 8'h00; sa = 8'h00; swd = 8'h00;
    case (op)
      3'd0, 3'd1: begin
        if (ind) begin
          ptr = ref_mem[bk*8 + int'(a[0])];
          two = 1;
          if (op == 3'd0) begin exp_rsp = 1; exp_d = ref_mem[ptr]; end
          else ref_mem[ptr] = wd;
        end else if (a >= 8'h80) begin
          if (a == 8'h81) begin
            if (op == 3'd0) begin exp_rsp = 1; exp_d = ref_sp; end
            else ref_sp = wd;
          end else if (op == 3'd0) begin
            ex_rd = 1; sa = a; exp_rsp = 1; exp_d = sfr_mem[a];
          end else begin
            ex_wr = 1; sa = a; swd = wd;
          end
        end else if (op == 3'd0) begin exp_rsp = 1; exp_d = ref_mem[a]; end
        else ref_mem[a] = wd;
      end
      3'd2: begin exp_rsp = 1; exp_d = ref_mem[bk*8 + int'(a[2:0])]; end
      3'd3: ref_mem[bk*8 + int'(a[2:0])] = wd;
      3'd4, 3'd5: begin
        if (a[7]) begin
          ex_rd = 1; sa = {a[7:3], 3'b000}; byt = sfr_mem[sa];
        end else begin
          byt = ref_mem[8'h20 + {4'h0, a[6:3]}];
        end
        if (op == 3'd4) begin exp_rsp = 1; exp_d = {7'd0, byt[a[2:0]]}; end
        else begin
          two = 1;
          byt[a[2:0]] = wd[0];
          if (a[7]) begin rmw_sfr = 1; swd = byt; end
          else ref_mem[8'h20 + {4'h0, a[6:3]}] = byt;
        end
      end
      3'd6: begin ref_sp = ref_sp + 8'd1; ref_mem[ref_sp] = wd; end
      default: begin exp_rsp = 1; exp_d = ref_mem[ref_sp]; ref_sp = ref_sp - 8'd1; end
    endcase

    req_valid = 1; req_op = op; req_indirect = ind; req_addr = a; req_wdata = wd;
    #1;
    chk({tag, " ready"}, req_ready, 1);
    chk({tag, " sfr_rd"}, sfr_rd, ex_rd);
    chk({tag, " sfr_wr"}, sfr_wr, ex_wr);
    if (ex_rd || ex_wr) chk({tag, " sfr_addr"}, sfr_addr, sa);
    if (ex_wr) chk({tag, " sfr_wdata"}, sfr_wdata, swd);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    #1;
    if (two) begin
      chk({tag, " busy"}, req_ready, 0);
      chk({tag, " early rsp"}, rsp_valid, 0);
      chk({tag, " rmw sfr_wr"}, sfr_wr, rmw_sfr);
      if (rmw_sfr) begin
        chk({tag, " rmw sfr_addr"}, sfr_addr, sa);
        chk({tag, " rmw sfr_wdata"}, sfr_wdata, swd);
      end
      @(negedge clk);
      #1;
    end
    chk({tag, " rsp_valid"}, rsp_valid, exp_rsp);
    if (exp_rsp) chk({tag, " rsp_rdata"}, rsp_rdata, exp_d);
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) sfr_mem[i] = 8'(i) ^ 8'h5A;
    ref_sp = 8'h07;
    rst_n = 0; req_valid = 0; req_op = 0; req_indirect = 0;
    req_addr = 0; req_wdata = 0; bank_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    // R1: reset state at the ports
    chk("R1 ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 sfr strobes", {sfr_rd, sfr_wr}, 0);
    @(negedge clk);
    run(3'd0, 0, 8'h81, 8'h00, "R1 sp reset");

    // R10: first push lands in R0 of bank 1
    run(3'd6, 0, 8'h00, 8'h11, "R10 push");
    bank_sel = 2'd1;
    run(3'd2, 0, 8'h00, 8'h00, "R10 bank1 R0");
    run(3'd0, 0, 8'h08, 8'h00, "R10 byte 08");
    run(3'd6, 0, 8'h00, 8'h22, "R10 push2");
    run(3'd0, 0, 8'h81, 8'h00, "R10 sp");
    run(3'd7, 0, 8'h00, 8'h00, "R11 pop");
    run(3'd7, 0, 8'h00, 8'h00, "R11 pop2");

    // R6 and R2: all banks through register and byte views
    for (int b = 0; b < 4; b++) begin
      bank_sel = 2'(b);
      for (int r = 0; r < 8; r++) run(3'd3, 0, 8'(r), 8'(b * 8 + r) ^ 8'hC3, "R6 reg wr");
    end
    for (int b = 0; b < 4; b++) begin
      bank_sel = 2'(b);
      for (int r = 0; r < 8; r++) run(3'd2, 0, 8'(r), 8'h00, "R6 reg rd");
    end
    for (int i = 0; i < 32; i += 5) run(3'd0, 0, 8'(i), 8'h00, "R2 byte view");
    run(3'd1, 0, 8'h5D, 8'h9E, "R2 wr");
    run(3'd0, 0, 8'h5D, 8'h00, "R2 rd");
    run(3'd1, 0, 8'h7F, 8'h01, "R2 wr top");
    run(3'd0, 0, 8'h7F, 8'h00, "R2 rd top");

    // R3: indirect into upper RAM via R0 and R1 of bank 2
    bank_sel = 2'd2;
    run(3'd3, 0, 8'h00, 8'h90, "R3 set R0");
    run(3'd3, 0, 8'h01, 8'h3A, "R3 set R1");
    run(3'd1, 1, 8'h00, 8'hA5, "R3 ind wr R0");
    run(3'd1, 1, 8'h01, 8'h6B, "R3 ind wr R1");
    run(3'd0, 1, 8'h00, 8'h00, "R3 ind rd R0");
    run(3'd0, 1, 8'h01, 8'h00, "R3 ind rd R1");
    run(3'd0, 0, 8'h3A, 8'h00, "R3 direct view");

    // R4: direct upper half goes to the bus, RAM keeps its byte
    run(3'd0, 0, 8'h90, 8'h00, "R4 sfr rd");
    run(3'd1, 0, 8'h90, 8'h77, "R4 sfr wr");
    run(3'd0, 0, 8'h90, 8'h00, "R4 sfr rd back");
    run(3'd0, 1, 8'h00, 8'h00, "R4 ram untouched");
    run(3'd1, 0, 8'hFF, 8'h12, "R4 sfr wr FF");

    // R5: stack pointer at 0x81
    run(3'd1, 0, 8'h81, 8'h40, "R5 sp wr");
    run(3'd0, 0, 8'h81, 8'h00, "R5 sp rd");

    // R7 and R8: bit window
    run(3'd1, 0, 8'h22, 8'h00, "R8 clear 22");
    run(3'd5, 0, 8'h13, 8'h01, "R8 set bit 13");
    run(3'd0, 0, 8'h22, 8'h00, "R8 byte 22");
    run(3'd4, 0, 8'h13, 8'h00, "R7 bit 13");
    run(3'd4, 0, 8'h12, 8'h00, "R7 bit 12");
    run(3'd1, 0, 8'h2F, 8'hFF, "R8 fill 2F");
    run(3'd5, 0, 8'h7F, 8'hFE, "R8 clear bit 7F");
    run(3'd0, 0, 8'h2F, 8'h00, "R8 byte 2F");
    run(3'd4, 0, 8'h00, 8'h00, "R7 bit 00");

    // R9: bit addresses above 0x7F on the bus
    run(3'd5, 0, 8'h93, 8'h01, "R9 sfr bit wr");
    run(3'd4, 0, 8'h93, 8'h00, "R9 sfr bit rd");
    run(3'd0, 0, 8'h90, 8'h00, "R9 sfr byte");
    run(3'd5, 0, 8'hA6, 8'h00, "R9 sfr bit clr");
    run(3'd0, 0, 8'hA0, 8'h00, "R9 sfr byte A0");

    // R11: wrap of the stack in both directions
    run(3'd1, 0, 8'h81, 8'hFF, "R11 sp FF");
    run(3'd6, 0, 8'h00, 8'h3C, "R11 push wrap");
    run(3'd0, 0, 8'h81, 8'h00, "R11 sp 00");
    run(3'd0, 0, 8'h00, 8'h00, "R11 byte 00");
    run(3'd7, 0, 8'h00, 8'h00, "R11 pop wrap");
    run(3'd0, 0, 8'h81, 8'h00, "R11 sp back");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule